// File: doc/BRIEF.md
# Line Buffer Configuration Selector

This block picks the memory arrangement of a vertical scaler's line buffer. For a given line width (already reduced to the smaller of the source and output widths), chroma line width, component depth, alpha usage and 4:2:0 flag, it works out how many whole lines fit into each candidate arrangement. It checks whether each arrangement holds enough lines for the vertical filter at the given downscale ratio. It reports the first arrangement that qualifies, together with the luma and chroma line counts it yields.

A request is a one-cycle `start` pulse with the operands held on the inputs. The block latches the operands and computes three line sizes with a shared iterative restoring divider. It then walks the candidates 1, 2, 3 and 0, doing three divisions per candidate. It finishes with a one-cycle `done` pulse. The results stay on the outputs until the next completion.

The state machine has the states IDLE, LINE_Y, LINE_C, LINE_A, PART_Y, PART_C, PART_A and JUDGE. The transitions are:
- IDLE to LINE_Y on `start`.
- Each division state to the next state in that list when the divider finishes.
- JUDGE to IDLE when the candidate qualifies or is the fallback.
- JUDGE back to PART_Y, with the next candidate, otherwise.

Top module: `lb_cfg_selector`

## Requirements
- R1: Line sizes are computed in memory words. Luma is ceil(w*bpc/72) and chroma is ceil(wc*bpc/72), where `bpc` is the plain binary value 6, 8, 10 or 12. Alpha is ceil(w/6). A width of 0 is handled as 1.
- R2: A line count is the candidate's memory size divided by the line size, rounded down. The memory sizes are:
  - Candidate 1: luma 816, chroma 816, alpha 984.
  - Candidate 2: luma 1088, chroma 1088, alpha 1312.
  - Candidate 3: luma 4448, chroma 1904, alpha 2752.
  - Candidate 0: 2752 for all three.
- R3: With `alpha_en` set, the luma line count is lowered to the alpha line count when the alpha count is smaller.
- R4: Both reported line counts are limited to at most 64.
- R5: A candidate qualifies when both luma and chroma fit. For a ratio above 2, fitting means taps + ratio <= lines + 2. Otherwise it means taps <= lines.
- R6: Candidates are tried in the order 1, 2, 3, 0, and candidate 3 is tried only when `is_420` is set. `cfg_sel` reports the candidate number in binary.
- R7: When no candidate qualifies, the block reports candidate 0 with its line counts and raises `fail`. Otherwise `fail` is low.
- R8: `busy` is high from the cycle after `start` until `done`. `done` lasts exactly one cycle, and the outputs hold their values until the next `done`.
- R9: A `start` pulse while `busy` is high is ignored. The running request completes with its original operands.
- R10: After reset, `busy`, `done`, `fail`, `cfg_sel`, `parts_y` and `parts_c` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when idle |
| line_w | input | WIDTH_W | Luma line width in pixels |
| line_w_c | input | WIDTH_W | Chroma line width in pixels |
| bpc | input | 4 | Bits per component: 6, 8, 10 or 12 |
| alpha_en | input | 1 | Alpha plane stored with luma |
| is_420 | input | 1 | 4:2:0 source, enables candidate 3 |
| vtaps_y | input | TAP_W | Luma vertical tap count |
| vtaps_c | input | TAP_W | Chroma vertical tap count |
| vratio_y | input | TAP_W | Ceiling of the luma vertical ratio |
| vratio_c | input | TAP_W | Ceiling of the chroma vertical ratio |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_sel | output | 2 | Chosen candidate number |
| parts_y | output | PART_W | Luma line count of the chosen candidate |
| parts_c | output | PART_W | Chroma line count of the chosen candidate |
| fail | output | 1 | Fallback candidate does not qualify either |

## Verification
The divider checks assume that no divisor is zero. This holds only because every line size is at least one word, which follows from handling a zero width as one and from `bpc` never being zero. The stimulus therefore draws `bpc` only from the four legal values, includes zero widths, and keeps tap counts and ratios between 1 and 8. The other checks assume that the operands are stable in the cycle `start` is sampled; the bench drives them on the falling edge before that.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;

    localparam int MEM_W = 13;

    typedef enum logic [1:0] {
        LBCFG_0 = 2'd0,
        LBCFG_1 = 2'd1,
        LBCFG_2 = 2'd2,
        LBCFG_3 = 2'd3
    } lb_cfg_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LINE_Y,
        S_LINE_C,
        S_LINE_A,
        S_PART_Y,
        S_PART_C,
        S_PART_A,
        S_JUDGE
    } lbsel_state_e;

    // Memory bank sizes in words that the candidates are assembled from
    localparam int BANK_A = 816;
    localparam int BANK_B = 1088;
    localparam int BANK_C = 848;
    localparam int ABANK_A = 984;
    localparam int ABANK_B = 1312;
    localparam int ABANK_C = 456;

    function automatic logic [MEM_W-1:0] luma_words(lb_cfg_e c);
        unique case (c)
            LBCFG_1: luma_words = MEM_W'(BANK_A);
            LBCFG_2: luma_words = MEM_W'(BANK_B);
            LBCFG_3: luma_words = MEM_W'(BANK_A + BANK_B + 3 * BANK_C);
            default: luma_words = MEM_W'(BANK_A + BANK_B + BANK_C);
        endcase
    endfunction

    function automatic logic [MEM_W-1:0] chroma_words(lb_cfg_e c);
        unique case (c)
            LBCFG_1: chroma_words = MEM_W'(BANK_A);
            LBCFG_2: chroma_words = MEM_W'(BANK_B);
            LBCFG_3: chroma_words = MEM_W'(BANK_A + BANK_B);
            default: chroma_words = MEM_W'(BANK_A + BANK_B + BANK_C);
        endcase
    endfunction

    function automatic logic [MEM_W-1:0] alpha_words(lb_cfg_e c);
        unique case (c)
            LBCFG_1: alpha_words = MEM_W'(ABANK_A);
            LBCFG_2: alpha_words = MEM_W'(ABANK_B);
            default: alpha_words = MEM_W'(ABANK_A + ABANK_B + ABANK_C);
        endcase
    endfunction

endpackage

// File: rtl/lbsel_divider.sv
module lbsel_divider #(
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          done,
    output logic [DW-1:0] quo
);
    localparam int CW = $clog2(DW + 1);
    localparam int PW = 2 * DW;

    logic [DW-1:0] rem_q;
    logic [DW-1:0] num_q;
    logic [DW-1:0] den_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [DW:0]   shifted;
    logic          take;

    assign shifted = {rem_q, quo[DW-1]};
    assign take    = shifted >= {1'b0, den_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            num_q <= '0;
            den_q <= '0;
            quo   <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo   <= num;
                num_q <= num;
                den_q <= den;
                cnt_q <= CW'(DW);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= take ? DW'(shifted - {1'b0, den_q}) : shifted[DW-1:0];
                quo   <= {quo[DW-2:0], take};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    // R1: line sizes are never zero, so no division by zero is issued
    a_r1_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> den != '0);

    // R2: the quotient is the rounded-down quotient of the latched operands
    a_r2_quotient_floor: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((PW'(quo) * PW'(den_q) <= PW'(num_q)) &&
                  ((PW'(quo) + PW'(1)) * PW'(den_q) > PW'(num_q))));

endmodule

// File: rtl/lbsel_fit.sv
module lbsel_fit #(
    parameter int TAP_W  = 4,
    parameter int PART_W = 7
) (
    input  logic [PART_W-1:0] lines,
    input  logic [TAP_W-1:0]  taps,
    input  logic [TAP_W-1:0]  ratio,
    output logic              ok
);
    localparam int EW = PART_W + 2;

    logic [EW-1:0] need;
    logic [EW-1:0] have;

    always_comb begin
        if (ratio > TAP_W'(2)) begin
            need = EW'(taps) + EW'(ratio);
            have = EW'(lines) + EW'(2);
        end else begin
            need = EW'(taps);
            have = EW'(lines);
        end
        ok = need <= have;
    end

endmodule

// File: rtl/lb_cfg_selector.sv
module lb_cfg_selector #(
    parameter int WIDTH_W  = 13,
    parameter int TAP_W    = 4,
    parameter int PART_MAX = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [WIDTH_W-1:0]            line_w,
    input  logic [WIDTH_W-1:0]            line_w_c,
    input  logic [3:0]                    bpc,
    input  logic                          alpha_en,
    input  logic                          is_420,
    input  logic [TAP_W-1:0]              vtaps_y,
    input  logic [TAP_W-1:0]              vtaps_c,
    input  logic [TAP_W-1:0]              vratio_y,
    input  logic [TAP_W-1:0]              vratio_c,
    output logic                          busy,
    output logic                          done,
    output logic [1:0]                    cfg_sel,
    output logic [$clog2(PART_MAX+1)-1:0] parts_y,
    output logic [$clog2(PART_MAX+1)-1:0] parts_c,
    output logic                          fail
);
    import lbsel_pkg::*;

    localparam int DW     = WIDTH_W + 5;
    localparam int PART_W = $clog2(PART_MAX + 1);
    localparam int WORD_BITS  = 72;
    localparam int ALPHA_PIX  = 6;

    lbsel_state_e state_q, state_d;
    lb_cfg_e      cur_q, cur_next;

    logic [WIDTH_W-1:0] w_q, wc_q;
    logic [3:0]         bpc_q;
    logic               alpha_q, f420_q;
    logic [TAP_W-1:0]   ty_q, tc_q, ry_q, rc_q;
    logic [DW-1:0]      ly_q, lc_q, la_q;
    logic [DW-1:0]      qy_q, qc_q, qa_q;

    logic               pend_q;
    logic               div_state;
    logic               div_go;
    logic               div_done;
    logic [DW-1:0]      div_num, div_den, div_quo;

    logic [DW-1:0]      y_lim;
    logic [PART_W-1:0]  py_clamp, pc_clamp;
    logic               fit_y, fit_c, accept;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start)    state_d = S_LINE_Y;
            S_LINE_Y: if (div_done) state_d = S_LINE_C;
            S_LINE_C: if (div_done) state_d = S_LINE_A;
            S_LINE_A: if (div_done) state_d = S_PART_Y;
            S_PART_Y: if (div_done) state_d = S_PART_C;
            S_PART_C: if (div_done) state_d = S_PART_A;
            S_PART_A: if (div_done) state_d = S_JUDGE;
            S_JUDGE:  state_d = accept ? S_IDLE : S_PART_Y;
            default:  state_d = S_IDLE;
        endcase
    end

    // ---------------- divider operand selection ----------------
    always_comb begin
        div_num   = '0;
        div_den   = DW'(1);
        div_state = 1'b1;
        unique case (state_q)
            S_LINE_Y: begin
                div_num = DW'(w_q) * DW'(bpc_q) + DW'(WORD_BITS - 1);
                div_den = DW'(WORD_BITS);
            end
            S_LINE_C: begin
                div_num = DW'(wc_q) * DW'(bpc_q) + DW'(WORD_BITS - 1);
                div_den = DW'(WORD_BITS);
            end
            S_LINE_A: begin
                div_num = DW'(w_q) + DW'(ALPHA_PIX - 1);
                div_den = DW'(ALPHA_PIX);
            end
            S_PART_Y: begin
                div_num = DW'(luma_words(cur_q));
                div_den = ly_q;
            end
            S_PART_C: begin
                div_num = DW'(chroma_words(cur_q));
                div_den = lc_q;
            end
            S_PART_A: begin
                div_num = DW'(alpha_words(cur_q));
                div_den = la_q;
            end
            default: div_state = 1'b0;
        endcase
    end

    assign div_go = div_state && !pend_q;

    lbsel_divider #(.DW(DW)) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    // ---------------- judging a candidate ----------------
    always_comb begin
        y_lim    = (alpha_q && (qa_q < qy_q)) ? qa_q : qy_q;
        py_clamp = (y_lim > DW'(PART_MAX)) ? PART_W'(PART_MAX) : y_lim[PART_W-1:0];
        pc_clamp = (qc_q  > DW'(PART_MAX)) ? PART_W'(PART_MAX) : qc_q[PART_W-1:0];
    end

    lbsel_fit #(.TAP_W(TAP_W), .PART_W(PART_W)) fit_y_i (
        .lines (py_clamp),
        .taps  (ty_q),
        .ratio (ry_q),
        .ok    (fit_y)
    );

    lbsel_fit #(.TAP_W(TAP_W), .PART_W(PART_W)) fit_c_i (
        .lines (pc_clamp),
        .taps  (tc_q),
        .ratio (rc_q),
        .ok    (fit_c)
    );

    assign accept = (fit_y && fit_c) || (cur_q == LBCFG_0);

    always_comb begin
        unique case (cur_q)
            LBCFG_1: cur_next = LBCFG_2;
            LBCFG_2: cur_next = f420_q ? LBCFG_3 : LBCFG_0;
            default: cur_next = LBCFG_0;
        endcase
    end

    // ---------------- operand and intermediate registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q     <= '0;
            wc_q    <= '0;
            bpc_q   <= '0;
            alpha_q <= 1'b0;
            f420_q  <= 1'b0;
            ty_q    <= '0;
            tc_q    <= '0;
            ry_q    <= '0;
            rc_q    <= '0;
            ly_q    <= DW'(1);
            lc_q    <= DW'(1);
            la_q    <= DW'(1);
            qy_q    <= '0;
            qc_q    <= '0;
            qa_q    <= '0;
            pend_q  <= 1'b0;
            cur_q   <= LBCFG_1;
        end else begin
            if (div_go)        pend_q <= 1'b1;
            else if (div_done) pend_q <= 1'b0;

            if (state_q == S_IDLE && start) begin
                w_q     <= (line_w   == '0) ? WIDTH_W'(1) : line_w;
                wc_q    <= (line_w_c == '0) ? WIDTH_W'(1) : line_w_c;
                bpc_q   <= bpc;
                alpha_q <= alpha_en;
                f420_q  <= is_420;
                ty_q    <= vtaps_y;
                tc_q    <= vtaps_c;
                ry_q    <= vratio_y;
                rc_q    <= vratio_c;
                cur_q   <= LBCFG_1;
            end

            if (div_done) begin
                unique case (state_q)
                    S_LINE_Y: ly_q <= div_quo;
                    S_LINE_C: lc_q <= div_quo;
                    S_LINE_A: la_q <= div_quo;
                    S_PART_Y: qy_q <= div_quo;
                    S_PART_C: qc_q <= div_quo;
                    S_PART_A: qa_q <= div_quo;
                    default: ;
                endcase
            end

            if (state_q == S_JUDGE && !accept) cur_q <= cur_next;
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            fail    <= 1'b0;
            cfg_sel <= 2'd0;
            parts_y <= '0;
            parts_c <= '0;
        end else begin
            done <= 1'b0;
            if (state_q == S_JUDGE && accept) begin
                done    <= 1'b1;
                fail    <= !(fit_y && fit_c);
                cfg_sel <= cur_q;
                parts_y <= py_clamp;
                parts_c <= pc_clamp;
            end
        end
    end

    assign busy = (state_q != S_IDLE);

    // ---------------- assertions ----------------
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(cfg_sel) && $stable(parts_y) && $stable(parts_c) && $stable(fail)));

    a_r7_fail_is_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fail) |-> cfg_sel == 2'd0);

    a_r4_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (parts_y <= PART_W'(PART_MAX) && parts_c <= PART_W'(PART_MAX)));

    a_r6_cfg3_needs_420: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_sel == 2'd3) |-> f420_q);

    a_r9_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r1_line_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_PART_Y |-> (ly_q != '0 && lc_q != '0 && la_q != '0));

endmodule

// File: tb/lb_cfg_selector_tb.sv
module lb_cfg_selector_tb_top;

    localparam int WIDTH_W = 13;
    localparam int TAP_W   = 4;
    localparam int PW      = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [WIDTH_W-1:0] line_w = '0, line_w_c = '0;
    logic [3:0] bpc = 4'd8;
    logic alpha_en = 1'b0, is_420 = 1'b0;
    logic [TAP_W-1:0] vtaps_y = 4'd1, vtaps_c = 4'd1, vratio_y = 4'd1, vratio_c = 4'd1;
    logic busy, done, fail;
    logic [1:0] cfg_sel;
    logic [PW-1:0] parts_y, parts_c;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    lb_cfg_selector #(.WIDTH_W(WIDTH_W), .TAP_W(TAP_W), .PART_MAX(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .line_w(line_w), .line_w_c(line_w_c), .bpc(bpc),
        .alpha_en(alpha_en), .is_420(is_420),
        .vtaps_y(vtaps_y), .vtaps_c(vtaps_c),
        .vratio_y(vratio_y), .vratio_c(vratio_c),
        .busy(busy), .done(done), .cfg_sel(cfg_sel),
        .parts_y(parts_y), .parts_c(parts_c), .fail(fail)
    );

    task automatic summary_and_exit();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish, cycles=%0d expected<190000", cycles);
            summary_and_exit();
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic bit fits(input int lines, input int taps, input int ratio);
        if (ratio > 2) return taps <= lines - ratio + 2;
        return taps <= lines;
    endfunction

    function automatic void model(input int w, input int wc, input int b, input int a,
                                  input int f420, input int ty, input int tc,
                                  input int ry, input int rc,
                                  output int cfg, output int py, output int pc,
                                  output int fl);
        int ly, lc, la, my, mc, ma, pa, c;
        int order[4] = '{1, 2, 3, 0};
        if (w == 0) w = 1;
        if (wc == 0) wc = 1;
        ly = cdiv(w * b, 72);
        lc = cdiv(wc * b, 72);
        la = cdiv(w, 6);
        cfg = 0; py = 0; pc = 0; fl = 1;
        for (int k = 0; k < 4; k++) begin
            c = order[k];
            if (c == 3 && f420 == 0) continue;
            case (c)
                1: begin my = 816;  mc = 816;  ma = 984;  end
                2: begin my = 1088; mc = 1088; ma = 1312; end
                3: begin my = 4448; mc = 1904; ma = 2752; end
                default: begin my = 2752; mc = 2752; ma = 2752; end
            endcase
            py = my / ly;
            pc = mc / lc;
            pa = ma / la;
            if (a != 0 && pa < py) py = pa;
            if (py > 64) py = 64;
            if (pc > 64) pc = 64;
            if ((fits(py, ty, ry) && fits(pc, tc, rc)) || c == 0) begin
                cfg = c;
                fl = (fits(py, ty, ry) && fits(pc, tc, rc)) ? 0 : 1;
                return;
            end
        end
    endfunction

    // Runs one request; if poke is set, a second start with another width is
    // pulsed while busy (R9). Checks results against the model.
    task automatic run_case(input int w, input int wc, input int b, input int a,
                            input int f420, input int ty, input int tc,
                            input int ry, input int rc, input bit poke,
                            input string tag);
        int ecfg, epy, epc, efl, guard;
        model(w, wc, b, a, f420, ty, tc, ry, rc, ecfg, epy, epc, efl);
        @(negedge clk);
        line_w = WIDTH_W'(w); line_w_c = WIDTH_W'(wc); bpc = 4'(b);
        alpha_en = a[0]; is_420 = f420[0];
        vtaps_y = 4'(ty); vtaps_c = 4'(tc); vratio_y = 4'(ry); vratio_c = 4'(rc);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R8 busy after start"}, int'(busy), 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            line_w = WIDTH_W'(w ^ 13'h0F0F);
            vtaps_y = 4'd8;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!done && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk({tag, " R8 done seen"}, int'(done), 1);
        chk({tag, " R6 cfg"}, int'(cfg_sel), ecfg);
        chk({tag, " R2 R3 R4 parts_y"}, int'(parts_y), epy);
        chk({tag, " R2 R4 parts_c"}, int'(parts_c), epc);
        chk({tag, " R5 R7 fail"}, int'(fail), efl);
        @(negedge clk);
        chk({tag, " R8 done one cycle"}, int'(done), 0);
        chk({tag, " R8 busy low"}, int'(busy), 0);
        chk({tag, " R8 cfg held"}, int'(cfg_sel), ecfg);
    endtask

    initial begin
        int seed;
        int bpcs[4] = '{6, 8, 10, 12};
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 busy", int'(busy), 0);
        chk("R10 done", int'(done), 0);
        chk("R10 fail", int'(fail), 0);
        chk("R10 cfg", int'(cfg_sel), 0);
        chk("R10 parts_y", int'(parts_y), 0);
        chk("R10 parts_c", int'(parts_c), 0);
        rst_n = 1'b1;

        // R1/R4: zero width handled as one, counts clamp to 64
        run_case(0, 0, 8, 0, 0, 4, 4, 1, 1, 0, "R1 zero width");
        chk("R1 R4 zero width parts_y", int'(parts_y), 64);
        // R3: alpha limits luma (luma 16 lines, alpha 9 lines)
        run_case(600, 600, 6, 1, 0, 4, 4, 1, 1, 0, "R3 alpha");
        chk("R3 alpha limited parts_y", int'(parts_y), 9);
        chk("R3 chroma unaffected", int'(parts_c), 16);
        // R7: nothing fits, fallback reported with fail
        run_case(4000, 2000, 12, 0, 0, 8, 4, 1, 1, 0, "R7 fallback");
        chk("R7 fail set", int'(fail), 1);
        chk("R7 fallback parts_y", int'(parts_y), 4);
        // R6: 4:2:0 reaches candidate 3
        run_case(4000, 2000, 12, 0, 1, 5, 4, 1, 1, 0, "R6 c3");
        chk("R6 candidate 3 chosen", int'(cfg_sel), 3);
        chk("R6 candidate 3 parts", int'(parts_y), 6);
        // R6: same operands without 4:2:0 skip candidate 3
        run_case(4000, 2000, 12, 0, 0, 5, 4, 1, 1, 0, "R6 skip c3");
        chk("R6 skip gives fallback", int'(cfg_sel), 0);
        // R5: ratio above 2 tightens the rule
        run_case(1920, 960, 8, 0, 0, 2, 2, 3, 1, 0, "R5 ratio3");
        run_case(1920, 960, 8, 0, 0, 2, 2, 2, 2, 0, "R5 ratio2");
        // R9: start while busy ignored
        run_case(1280, 640, 10, 0, 1, 4, 4, 4, 4, 1, "R9 poke");
        // widest width, all depths
        for (int i = 0; i < 4; i++)
            run_case(8191, 8191, bpcs[i], 1, 1, 8, 8, 8, 8, 0, "R1 max width");

        for (int n = 0; n < 120; n++) begin
            run_case(int'($urandom_range(0, 4095)), int'($urandom_range(0, 4095)),
                     bpcs[$urandom_range(0, 3)], int'($urandom_range(0, 1)),
                     int'($urandom_range(0, 1)),
                     int'($urandom_range(1, 8)), int'($urandom_range(1, 8)),
                     int'($urandom_range(1, 8)), int'($urandom_range(1, 8)),
                     (n % 10) == 0, "random");
        end
        summary_and_exit();
    end

endmodule